// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog peripheral driven by a slow half-second tick and controlled through five 16-bit registers on a halfword-stride bus. Once software turns it on it cannot be turned off. It counts down from a programmable value, and the count is restored only when software writes a two-word key sequence to the service register. If software fails to service it in time, the block either raises an internal reset request or pulls an external reset pin low, depending on a routing bit. The reset output is held for a fixed number of ticks.

Software can ask for an early warning: an interrupt fires a programmable number of half-seconds before expiry and stays pending until it is acknowledged. A status register that only power-on reset clears records whether the last reset came from a timeout or from the software reset request. Software can also drive the external pin directly, and it can request a software reset with an active-low bit that must be written twice within one tick period. A power-down counter runs from reset and pulses the active-low interrupt line for one clock unless software writes zero to the misc register.

Top module: `wdog_svc_timer`

## Requirements
- R1: After reset the registers read: control (offset 0x0) 0x0030, interrupt control (0x6) 0x0000, misc (0x8) 0x0001, status (0x4) 0x0000; `irq_n` and `ext_rst_n` are 1 and `int_rst` is 0.
- R2: With timeout field F in control bits [15:8], enable in bit 2 and route bit 3 at 0, `int_rst` asserts on the (F+1)-th tick after enable and not earlier.
- R3: With route bit 3 set, expiry pulls `ext_rst_n` low instead and leaves `int_rst` at 0.
- R4: A reset output, once asserted, stays asserted for RST_TICKS further ticks and then releases.
- R5: Writing 0x5555 and then 0xAAAA to the service register (0x2) reloads the count to F. A lone 0xAAAA or any other word between the two does not reload. A repeated 0x5555 re-arms the sequence.
- R6: The enable bit can be set but not cleared: writing 0 to bit 2 leaves it at 1 and the countdown running.
- R7: Control bit 0 (low-power suspend) takes only the first control write after reset. While it is 1 and `low_power` is high, ticks do not count.
- R8: A new timeout field written while running is used only from the next reload; the current countdown finishes with the old value.
- R9: With interrupt control bit 15 set and pre-timeout P in bits [7:0], status bit 14 sets when the count steps down to P. `irq_n` is then low until software writes 1 to bit 14. Writing 0 to bit 14 leaves the status unchanged.
- R10: Status bit 1 is set by a timeout and bit 0 by a software reset. The register keeps its value through `rst_n` and clears only on `por_n`.
- R11: Control bit 4 written 0 requests a software reset. The request takes effect only on the second such write within one tick period, and bit 4 always reads 1.
- R12: Control bit 5 at 0 drives `ext_rst_n` low directly; at 1 it releases it.
- R13: Unless misc bit 0 has been written 0, `irq_n` pulses low for exactly one clock after PD_TICKS ticks from reset. After that write, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low block reset, leaves the cause record intact |
| por_n | input | 1 | Active-low power-on reset, also clears the cause record |
| tick | input | 1 | One-clock pulse per half-second of the slow clock |
| low_power | input | 1 | High while the chip is in a low-power mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the register at `addr` |
| irq_n | output | 1 | Active-low interrupt: pre-timeout or power-down pulse |
| int_rst | output | 1 | Internal reset request |
| ext_rst_n | output | 1 | Active-low external reset pin |

## Verification
The bench builds the block with RST_TICKS=3 and PD_TICKS=6. With these values the release of the reset hold and the one-clock power-down pulse both fall within a few ticks, so each can be observed at the exact tick where it must happen. The 8-bit timeout field is kept, but the bench programs small values from 2 to 9. Every expiry, reload and pre-timeout edge is therefore counted tick by tick within a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int TW = 8;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_SVC  = 4'h2;
  localparam logic [3:0] OFS_STAT = 4'h4;
  localparam logic [3:0] OFS_ICTL = 4'h6;
  localparam logic [3:0] OFS_MISC = 4'h8;
  localparam logic [15:0] KEY_ARM  = 16'h5555;
  localparam logic [15:0] KEY_FIRE = 16'hAAAA;

  // next value of the countdown on a counting tick
  function automatic logic [TW-1:0] next_count(logic [TW-1:0] cnt, logic [TW-1:0] field);
    return (cnt == '0) ? field : cnt - TW'(1);
  endfunction

  // true when this tick brings the count down onto the warning value
  function automatic logic pre_hit(logic [TW-1:0] cnt, logic [TW-1:0] pre);
    return (cnt != '0) && ((cnt - TW'(1)) == pre);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [15:0]   wdata,
  input  logic          pre_evt,
  input  logic [1:0]    cause,
  output logic [15:0]   rdata,
  output logic [TW-1:0] field_o,
  output logic          en_o,
  output logic          route_o,
  output logic          pin_n_o,
  output logic          lp_sus_o,
  output logic          swr_req_o,
  output logic          ie_o,
  output logic [TW-1:0] pre_o,
  output logic          irq_st_o,
  output logic          pd_on_o,
  output logic          svc_wr_o
);
  logic wr_ctrl, wr_ictl, wr_misc;
  logic sus_lock;

  assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
  assign wr_ictl   = wr_en && (addr == OFS_ICTL);
  assign wr_misc   = wr_en && (addr == OFS_MISC);
  assign svc_wr_o  = wr_en && (addr == OFS_SVC);
  assign swr_req_o = wr_ctrl && !wdata[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_o  <= '0;
      en_o     <= 1'b0;
      route_o  <= 1'b0;
      pin_n_o  <= 1'b1;
      lp_sus_o <= 1'b0;
      sus_lock <= 1'b0;
      ie_o     <= 1'b0;
      pre_o    <= '0;
      irq_st_o <= 1'b0;
      pd_on_o  <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        field_o <= wdata[15:8];
        route_o <= wdata[3];
        pin_n_o <= wdata[5];
        if (wdata[2]) en_o <= 1'b1;
        if (!sus_lock) begin
          lp_sus_o <= wdata[0];
          sus_lock <= 1'b1;
        end
      end
      if (wr_ictl) begin
        ie_o  <= wdata[15];
        pre_o <= wdata[7:0];
      end
      if (pre_evt) irq_st_o <= 1'b1;
      else if (wr_ictl && wdata[14]) irq_st_o <= 1'b0;
      if (wr_misc && !wdata[0]) pd_on_o <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = {field_o, 2'b00, pin_n_o, 1'b1, route_o, en_o, 1'b0, lp_sus_o};
      OFS_STAT: rdata = {14'd0, cause};
      OFS_ICTL: rdata = {ie_o, irq_st_o, 6'd0, pre_o};
      OFS_MISC: rdata = {15'd0, pd_on_o};
      default:  rdata = 16'h0000;
    endcase
  end

  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_o) |-> en_o);
  // R9
  ist_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_evt |=> irq_st_o);
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] wdata,
  output logic        reload_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      reload_o <= svc_wr && armed && (wdata == KEY_FIRE);
      if (svc_wr) armed <= (wdata == KEY_ARM);
    end
  end

  // R5
  seq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |-> $past(svc_wr && wdata == KEY_FIRE));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          hold,
  input  logic [TW-1:0] field,
  input  logic [TW-1:0] pre,
  input  logic          ie,
  input  logic          reload,
  output logic          expire_o,
  output logic          pre_evt_o
);
  logic [TW-1:0] cnt;
  logic          en_q, load, run;

  assign load      = reload || (en && !en_q);
  assign run       = en && !hold && tick && !load;
  assign expire_o  = run && (cnt == '0);
  assign pre_evt_o = run && ie && pre_hit(cnt, pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (load)     cnt <= field;
      else if (run) cnt <= next_count(cnt, field);
    end
  end
endmodule

// File: rtl/wdog_rst.sv
module wdog_rst #(
  parameter int RST_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       tick,
  input  logic       expire,
  input  logic       route,
  input  logic       swr_req,
  input  logic       pin_n,
  output logic       int_rst_o,
  output logic       ext_rst_n_o,
  output logic [1:0] cause_o
);
  localparam int HW = $clog2(RST_TICKS + 1);
  logic [HW-1:0] ihold, ehold;
  logic sw1, swr_fire, int_fire, ext_fire;

  assign swr_fire = swr_req && sw1;
  assign int_fire = swr_fire || (expire && !route);
  assign ext_fire = expire && route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw1   <= 1'b0;
      ihold <= '0;
      ehold <= '0;
    end else begin
      if (swr_fire)     sw1 <= 1'b0;
      else if (tick)    sw1 <= swr_req;
      else if (swr_req) sw1 <= 1'b1;
      if (int_fire)                 ihold <= HW'(RST_TICKS);
      else if (tick && ihold != '0) ihold <= ihold - HW'(1);
      if (ext_fire)                 ehold <= HW'(RST_TICKS);
      else if (tick && ehold != '0) ehold <= ehold - HW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_o <= 2'b00;
    else if (expire) cause_o <= 2'b10;
    else if (swr_fire) cause_o <= 2'b01;
  end

  assign int_rst_o   = (ihold != '0);
  assign ext_rst_n_o = (ehold == '0) && pin_n;

  // R2
  int_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !route) |=> int_rst_o);
  // R3
  ext_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && route) |=> !ext_rst_n_o);
endmodule

// File: rtl/wdog_svc_timer.sv
module wdog_svc_timer
  import wdog_pkg::*;
#(
  parameter int RST_TICKS = 4,
  parameter int PD_TICKS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        tick,
  input  logic        low_power,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq_n,
  output logic        int_rst,
  output logic        ext_rst_n
);
  localparam int PW = $clog2(PD_TICKS + 1);

  logic [TW-1:0] field, pre;
  logic en, route, pin_n, lp_sus, swr_req, ie, irq_st, pd_on, svc_wr;
  logic reload, expire, pre_evt;
  logic [1:0] cause;
  logic [PW-1:0] pdc;
  logic pd_done, pd_pulse;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pre_evt(pre_evt), .cause(cause), .rdata(rdata), .field_o(field),
    .en_o(en), .route_o(route), .pin_n_o(pin_n), .lp_sus_o(lp_sus),
    .swr_req_o(swr_req), .ie_o(ie), .pre_o(pre), .irq_st_o(irq_st),
    .pd_on_o(pd_on), .svc_wr_o(svc_wr)
  );

  wdog_seq u_seq (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wdata(wdata), .reload_o(reload)
  );

  wdog_count u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .hold(lp_sus && low_power),
    .field(field), .pre(pre), .ie(ie), .reload(reload),
    .expire_o(expire), .pre_evt_o(pre_evt)
  );

  wdog_rst #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .expire(expire),
    .route(route), .swr_req(swr_req), .pin_n(pin_n),
    .int_rst_o(int_rst), .ext_rst_n_o(ext_rst_n), .cause_o(cause)
  );

  // power-down counter: one-clock pulse on the interrupt line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdc      <= '0;
      pd_done  <= 1'b0;
      pd_pulse <= 1'b0;
    end else begin
      pd_pulse <= 1'b0;
      if (pd_on && !pd_done && tick) begin
        pdc <= pdc + PW'(1);
        if (pdc == PW'(PD_TICKS - 1)) begin
          pd_pulse <= 1'b1;
          pd_done  <= 1'b1;
        end
      end
    end
  end

  assign irq_n = !((ie && irq_st) || pd_pulse);

  // R13
  pd_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pulse |=> !pd_pulse);
endmodule

// File: tb/wdog_svc_timer_tb.sv
module wdog_svc_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0, tick = 1'b0, low_power = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic irq_n, int_rst, ext_rst_n;
  int compared = 0, mismatched = 0, cyc = 0;
  logic saw_low;

  always #2.5 clk = ~clk;

  wdog_svc_timer #(.RST_TICKS(3), .PD_TICKS(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .low_power(low_power),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_n(irq_n), .int_rst(int_rst), .ext_rst_n(ext_rst_n)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit por);
    @(negedge clk);
    rst_n = 1'b0; if (por) por_n = 1'b0;
    tick = 1'b0; wr_en = 1'b0; low_power = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (!irq_n) saw_low = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset(1);
    rd("R1 ctrl", 4'h0, 16'h0030);
    rd("R1 ictl", 4'h6, 16'h0000);
    rd("R1 misc", 4'h8, 16'h0001);
    rd("R1 stat", 4'h4, 16'h0000);
    chk("R1 irq_n", irq_n, 1); chk("R1 int_rst", int_rst, 0); chk("R1 ext_rst_n", ext_rst_n, 1);
  endtask

  task automatic t_timeout();
    do_reset(1); wr(4'h8, 0); wr(4'h0, 16'h0534);
    ticks(5); chk("R2 before expiry", int_rst, 0);
    ticks(1); chk("R2 at expiry", int_rst, 1); chk("R2 pin untouched", ext_rst_n, 1);
    rd("R10 timeout cause", 4'h4, 16'h0002);
    ticks(2); chk("R4 still held", int_rst, 1);
    ticks(1); chk("R4 released", int_rst, 0);
    do_reset(0); rd("R10 kept through rst_n", 4'h4, 16'h0002);
    do_reset(1); rd("R10 cleared by por_n", 4'h4, 16'h0000);
  endtask

  task automatic t_ext();
    do_reset(1); wr(4'h8, 0); wr(4'h0, 16'h033C);
    ticks(3); chk("R3 before expiry", ext_rst_n, 1);
    ticks(1); chk("R3 pin low", ext_rst_n, 0); chk("R3 no internal", int_rst, 0);
    ticks(3); chk("R4 pin released", ext_rst_n, 1);
  endtask

  task automatic svc_case(string tag, logic [15:0] w0, logic [15:0] w1, logic [15:0] w2,
                          int nw, bit reload_exp);
    do_reset(1); wr(4'h8, 0); wr(4'h0, 16'h0334);
    ticks(3);
    wr(4'h2, w0);
    if (nw > 1) wr(4'h2, w1);
    if (nw > 2) wr(4'h2, w2);
    ticks(1);
    chk(tag, int_rst, reload_exp ? 16'd0 : 16'd1);
  endtask

  task automatic t_service();
    svc_case("R5 proper key reloads", 16'h5555, 16'hAAAA, 0, 2, 1);
    svc_case("R5 lone second word", 16'hAAAA, 0, 0, 1, 0);
    svc_case("R5 stray word breaks", 16'h5555, 16'h1234, 16'hAAAA, 3, 0);
    svc_case("R5 repeated arm", 16'h5555, 16'h5555, 16'hAAAA, 3, 1);
    ticks(3); chk("R5 reload restores full count", int_rst, 1);
  endtask

  task automatic t_once();
    do_reset(1); wr(4'h8, 0); wr(4'h0, 16'h0335);
    wr(4'h0, 16'h0330);
    rd("R6 R7 write-once bits", 4'h0, 16'h0335);
    low_power = 1'b1; ticks(10);
    chk("R7 suspended", int_rst, 0);
    low_power = 1'b0; ticks(3);
    chk("R6 still counting", int_rst, 0);
    ticks(1); chk("R6 expiry after disable attempt", int_rst, 1);
  endtask

  task automatic t_newfield();
    do_reset(1); wr(4'h8, 0); wr(4'h0, 16'h0234); wr(4'h0, 16'h0934);
    ticks(2); chk("R8 old count", int_rst, 0);
    ticks(1); chk("R8 old value used", int_rst, 1);
    do_reset(1); wr(4'h8, 0); wr(4'h0, 16'h0234); wr(4'h0, 16'h0534);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(5); chk("R8 new value after reload", int_rst, 0);
    ticks(1); chk("R8 expiry with new value", int_rst, 1);
  endtask

  task automatic t_pre();
    do_reset(1); wr(4'h8, 0); wr(4'h6, 16'h8002); wr(4'h0, 16'h0734);
    ticks(4); chk("R9 quiet", irq_n, 1); rd("R9 status clear", 4'h6, 16'h8002);
    ticks(1); chk("R9 irq", irq_n, 0); rd("R9 status set", 4'h6, 16'hC002);
    wr(4'h6, 16'h8002); chk("R9 write 0 keeps", irq_n, 0);
    wr(4'h6, 16'hC002); chk("R9 write 1 clears", irq_n, 1);
    rd("R9 status after clear", 4'h6, 16'h8002);
  endtask

  task automatic t_swr();
    do_reset(1); wr(4'h8, 0);
    wr(4'h0, 16'h0020); ticks(1);
    wr(4'h0, 16'h0020); chk("R11 one write per period", int_rst, 0);
    rd("R11 bit reads one", 4'h0, 16'h0030);
    wr(4'h0, 16'h0020); chk("R11 double write fires", int_rst, 1);
    rd("R10 software cause", 4'h4, 16'h0001);
  endtask

  task automatic t_pin();
    do_reset(1); wr(4'h8, 0);
    wr(4'h0, 16'h0010); chk("R12 pin low", ext_rst_n, 0); chk("R12 no internal", int_rst, 0);
    wr(4'h0, 16'h0030); chk("R12 pin high", ext_rst_n, 1);
  endtask

  task automatic t_pd();
    do_reset(1); saw_low = 1'b0;
    ticks(5); chk("R13 no early pulse", saw_low, 0);
    ticks(1); chk("R13 pulse", saw_low, 1);
    @(negedge clk); chk("R13 pulse one clock", irq_n, 1);
    do_reset(1); wr(4'h8, 0); saw_low = 1'b0;
    ticks(8); chk("R13 disabled", saw_low, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL run-time limit: actual cycles %0d expected below %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timeout();
    t_ext();
    t_service();
    t_once();
    t_newfield();
    t_pre();
    t_swr();
    t_pin();
    t_pd();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule